// File: doc/BRIEF.md
# Decoded Parallel I/O Port Interface

This block is a peripheral for an 8-bit I/O bus. It has three 8-bit general-purpose ports, A, B and C, and a control register that sets the direction of each port. The block has its own address decoder. The decoder raises chip select only in an I/O cycle, and only when a fixed group of six address bits matches a base pattern. The two remaining address bits pick one of four locations.

A synthesis-time parameter selects one of two address maps.
- **Default map:** the select bits are address bits 1 and 0, so the four locations sit at consecutive addresses.
- **Alternate map:** the select bits are address bits 3 and 1, so the four locations sit at scattered addresses.

Each port has an output latch and a per-bit output enable. A read of an input bit returns the live pin. A read of an output bit returns the latch.

Top module: `pio_decoded_top`

## Requirements
- R1: A synchronous reset loads the control word 0x9B, which makes every port an input. It clears all three output latches to 0x00 and drives every output-enable bit to 0.
- R2: With MAP_ALT=0, chip select needs address bits 7..2 equal to 100111. The location code is address bits 1..0, and the locations are port A at 0x9C, port B at 0x9D, port C at 0x9E and control at 0x9F.
- R3: With MAP_ALT=1, chip select needs address bits 7,6,5,4,2,0 equal to 0,1,0,1,1,0. The location code is {bit 3, bit 1}, and the locations are port A at 0x54, port B at 0x56, port C at 0x5C and control at 0x5E.
- R4: While io_cycle is 0, or while the decoded address bits do not match, the block is deselected. In that state rd_valid stays 0 and a write changes no latch or control bit.
- R5: A selected write to control with bit 7 = 1 loads the whole word. The direction bits are:
  - bit 4 = 1 makes port A an input;
  - bit 1 = 1 makes port B an input;
  - bit 3 = 1 makes the upper nibble of port C an input;
  - bit 0 = 1 makes the lower nibble of port C an input.

  An input bit has its output enable at 0, and an output bit has it at 1.
- R6: A control write with bit 7 = 0 is ignored. The port directions and the control word read back afterwards are unchanged.
- R7: A selected write to a port loads its output latch at that clock edge. The latch drives the port's out pins from the next cycle.
- R8: A port read returns, bit by bit, the live input pin where the bit is an input and the output latch where the bit is an output. For port C this choice is made separately for each nibble.
- R9: rd_valid is 1 exactly while the block is selected, rd_stb is 1 and wr_stb is 0. When rd_valid is 0, rd_data is 0x00.
- R10: A cycle with rd_stb and wr_stb both at 1 is a no-operation. It returns no data and changes no latch or control bit.
- R11: A read of the control location returns the current control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | Bus address |
| io_cycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| wr_data | input | 8 | Write data from the bus |
| rd_data | output | 8 | Read data, valid while rd_valid is 1 |
| rd_valid | output | 1 | Read data is being driven |
| pa_pin_in | input | 8 | Port A pin input |
| pa_pin_out | output | 8 | Port A output latch |
| pa_pin_oe | output | 8 | Port A per-bit output enable |
| pb_pin_in | input | 8 | Port B pin input |
| pb_pin_out | output | 8 | Port B output latch |
| pb_pin_oe | output | 8 | Port B per-bit output enable |
| pc_pin_in | input | 8 | Port C pin input |
| pc_pin_out | output | 8 | Port C output latch |
| pc_pin_oe | output | 8 | Port C per-bit output enable |

## Verification
The assertions assume that the bus inputs are known and steady across each clock edge. They also assume a write strobe lasts exactly one cycle, so that the cycle after a write shows only that write's effect. The stimulus changes the inputs one nanosecond after each rising edge and holds each strobe for one cycle. It also returns the bus to idle between operations.

Two instances, one per address map, share the same bus. Each address in the stimulus therefore selects at most one of them, and the other instance must remain deselected.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int N_PORTS = 3;

    typedef enum logic [1:0] {
        LOC_A    = 2'd0,
        LOC_B    = 2'd1,
        LOC_C    = 2'd2,
        LOC_CTRL = 2'd3
    } loc_e;

    typedef struct packed {
        logic       mode_flag;
        logic [1:0] spare_hi;
        logic       a_in;
        logic       c_hi_in;
        logic       spare_mid;
        logic       b_in;
        logic       c_lo_in;
    } ctrl_t;

    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h9B;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rd_rsp_t;

    function automatic logic [ADDR_W-1:0] map_mask(input bit alt);
        return alt ? 8'hF5 : 8'hFC;
    endfunction

    function automatic logic [ADDR_W-1:0] map_match(input bit alt);
        return alt ? 8'h54 : 8'h9C;
    endfunction

    function automatic int map_sel_hi(input bit alt);
        return alt ? 3 : 1;
    endfunction

    function automatic int map_sel_lo(input bit alt);
        return alt ? 1 : 0;
    endfunction

    // {upper nibble is input, lower nibble is input} for a port index
    function automatic logic [1:0] port_dir(input ctrl_t c, input int idx);
        logic [1:0] d;
        case (idx)
            0:       d = {c.a_in, c.a_in};
            1:       d = {c.b_in, c.b_in};
            default: d = {c.c_hi_in, c.c_lo_in};
        endcase
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] dir_to_oe(input logic [1:0] d);
        return {{(DATA_W/2){~d[1]}}, {(DATA_W/2){~d[0]}}};
    endfunction

endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode
    import pio_pkg::*;
#(
    parameter bit MAP_ALT = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_cycle,
    output logic              cs,
    output loc_e              loc
);
    localparam logic [ADDR_W-1:0] MASK  = map_mask(MAP_ALT);
    localparam logic [ADDR_W-1:0] MATCH = map_match(MAP_ALT);
    localparam int                SEL_H = map_sel_hi(MAP_ALT);
    localparam int                SEL_L = map_sel_lo(MAP_ALT);

    always_comb begin
        cs  = io_cycle && ((addr & MASK) == MATCH);
        loc = loc_e'({addr[SEL_H], addr[SEL_L]});
    end
endmodule

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(CTRL_RESET);
        end else if (wr_en && wr_data[DATA_W-1]) begin
            ctrl_q <= ctrl_t'(wr_data);
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        dir_in,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (wr_en) begin
            latch_q <= wr_data;
        end
    end

    always_comb begin
        pin_oe  = dir_to_oe(dir_in);
        pin_out = latch_q;
        rd_val  = (latch_q & pin_oe) | (pin_in & ~pin_oe);
    end
endmodule

// File: rtl/pio_decoded_top.sv
module pio_decoded_top
    import pio_pkg::*;
#(
    parameter bit MAP_ALT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_cycle,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [DATA_W-1:0] pa_pin_in,
    output logic [DATA_W-1:0] pa_pin_out,
    output logic [DATA_W-1:0] pa_pin_oe,
    input  logic [DATA_W-1:0] pb_pin_in,
    output logic [DATA_W-1:0] pb_pin_out,
    output logic [DATA_W-1:0] pb_pin_oe,
    input  logic [DATA_W-1:0] pc_pin_in,
    output logic [DATA_W-1:0] pc_pin_out,
    output logic [DATA_W-1:0] pc_pin_oe
);
    logic    cs_w;
    loc_e    loc_w;
    logic    do_wr;
    logic    do_rd;
    ctrl_t   ctrl_w;
    rd_rsp_t rsp;

    logic [DATA_W-1:0] pin_in_arr  [N_PORTS];
    logic [DATA_W-1:0] pin_out_arr [N_PORTS];
    logic [DATA_W-1:0] pin_oe_arr  [N_PORTS];
    logic [DATA_W-1:0] rd_arr      [N_PORTS];

    pio_addr_decode #(.MAP_ALT(MAP_ALT)) u_dec (
        .addr     (io_addr),
        .io_cycle (io_cycle),
        .cs       (cs_w),
        .loc      (loc_w)
    );

    assign do_wr = cs_w && wr_stb && !rd_stb;
    assign do_rd = cs_w && rd_stb && !wr_stb;

    pio_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (do_wr && (loc_w == LOC_CTRL)),
        .wr_data (wr_data),
        .ctrl    (ctrl_w)
    );

    assign pin_in_arr[0] = pa_pin_in;
    assign pin_in_arr[1] = pb_pin_in;
    assign pin_in_arr[2] = pc_pin_in;

    for (genvar g = 0; g < N_PORTS; g++) begin : g_port
        pio_port u_port (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (do_wr && (loc_w == loc_e'(g))),
            .wr_data (wr_data),
            .dir_in  (port_dir(ctrl_w, g)),
            .pin_in  (pin_in_arr[g]),
            .pin_out (pin_out_arr[g]),
            .pin_oe  (pin_oe_arr[g]),
            .rd_val  (rd_arr[g])
        );
    end

    assign pa_pin_out = pin_out_arr[0];
    assign pb_pin_out = pin_out_arr[1];
    assign pc_pin_out = pin_out_arr[2];
    assign pa_pin_oe  = pin_oe_arr[0];
    assign pb_pin_oe  = pin_oe_arr[1];
    assign pc_pin_oe  = pin_oe_arr[2];

    always_comb begin
        rsp = '0;
        if (do_rd) begin
            rsp.valid = 1'b1;
            case (loc_w)
                LOC_A:    rsp.data = rd_arr[0];
                LOC_B:    rsp.data = rd_arr[1];
                LOC_C:    rsp.data = rd_arr[2];
                default:  rsp.data = ctrl_w;
            endcase
        end
    end

    assign rd_data  = rsp.data;
    assign rd_valid = rsp.valid;
endmodule

// File: rtl/pio_decoded_chk.sv
module pio_decoded_chk
    import pio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              io_cycle,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              cs,
    input logic [1:0]        loc,
    input logic [DATA_W-1:0] pa_pin_out,
    input logic [DATA_W-1:0] pa_pin_oe,
    input logic [DATA_W-1:0] pb_pin_out,
    input logic [DATA_W-1:0] pb_pin_oe,
    input logic [DATA_W-1:0] pc_pin_out,
    input logic [DATA_W-1:0] pc_pin_oe
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (pa_pin_out == 8'h00 && pb_pin_out == 8'h00 &&
                        pc_pin_out == 8'h00 && pa_pin_oe == 8'h00 &&
                        pb_pin_oe == 8'h00 && pc_pin_oe == 8'h00));

    // R4
    deselect_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        !io_cycle |-> !rd_valid);

    // R9
    valid_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_stb && !wr_stb && cs));

    // R9
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == 8'h00);

    // R6
    ctrl_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && wr_stb && !rd_stb && loc == 2'd3 && !wr_data[7]) |=>
        $stable({pa_pin_oe, pb_pin_oe, pc_pin_oe}));

    // R7
    port_a_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cs && wr_stb && !rd_stb && loc == 2'd0) |=> pa_pin_out == $past(wr_data));

    // R10
    collide_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && wr_stb) |=>
        $stable({pa_pin_out, pb_pin_out, pc_pin_out, pa_pin_oe, pb_pin_oe, pc_pin_oe}));
endmodule

bind pio_decoded_top pio_decoded_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_cycle   (io_cycle),
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .cs         (cs_w),
    .loc        (loc_w),
    .pa_pin_out (pa_pin_out),
    .pa_pin_oe  (pa_pin_oe),
    .pb_pin_out (pb_pin_out),
    .pb_pin_oe  (pb_pin_oe),
    .pc_pin_out (pc_pin_out),
    .pc_pin_oe  (pc_pin_oe)
);

// File: tb/tb_pio_decoded_top.sv
module tb_pio_decoded_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] io_addr = 8'h00;
    logic       io_cycle = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;

    logic [7:0] rd0, pa_o0, pa_e0, pb_o0, pb_e0, pc_o0, pc_e0;
    logic       vld0;
    logic [7:0] rd1, pa_o1, pa_e1, pb_o1, pb_e1, pc_o1, pc_e1;
    logic       vld1;

    int errors = 0;
    int checks = 0;

    typedef struct {
        int         unit;
        logic       exp_vld;
        logic [7:0] exp_data;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    pio_decoded_top #(.MAP_ALT(1'b0)) dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_cycle(io_cycle),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_data(rd0), .rd_valid(vld0),
        .pa_pin_in(pa_in), .pa_pin_out(pa_o0), .pa_pin_oe(pa_e0),
        .pb_pin_in(pb_in), .pb_pin_out(pb_o0), .pb_pin_oe(pb_e0),
        .pc_pin_in(pc_in), .pc_pin_out(pc_o0), .pc_pin_oe(pc_e0)
    );

    pio_decoded_top #(.MAP_ALT(1'b1)) dut_alt (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_cycle(io_cycle),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_data(rd1), .rd_valid(vld1),
        .pa_pin_in(pa_in), .pa_pin_out(pa_o1), .pa_pin_oe(pa_e1),
        .pb_pin_in(pb_in), .pb_pin_out(pb_o1), .pb_pin_oe(pb_e1),
        .pc_pin_in(pc_in), .pc_pin_out(pc_o1), .pc_pin_oe(pc_e1)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compares the read response of the chosen instance mid-cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [7:0] d;
            logic v;
            it = sb_q.pop_front();
            d = (it.unit == 0) ? rd0 : rd1;
            v = (it.unit == 0) ? vld0 : vld1;
            checks++;
            if (v !== it.exp_vld || (it.exp_vld && d !== it.exp_data) ||
                (!it.exp_vld && d !== 8'h00)) begin
                errors++;
                $display("FAIL %s: actual vld=%0b data=%02h expected vld=%0b data=%02h",
                         it.tag, v, d, it.exp_vld, it.exp_data);
            end
        end
    end

    task automatic bus_read(input logic [7:0] a, input logic io, input int unit,
                            input logic ev, input logic [7:0] ed, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        io_addr = a; io_cycle = io; rd_stb = 1'b1;
        it.unit = unit; it.exp_vld = ev; it.exp_data = ed; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        rd_stb = 1'b0; io_cycle = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic io, input logic [7:0] d,
                             input logic with_rd);
        @(posedge clk); #1;
        io_addr = a; io_cycle = io; wr_data = d; wr_stb = 1'b1; rd_stb = with_rd;
        @(posedge clk); #1;
        wr_stb = 1'b0; rd_stb = 1'b0; io_cycle = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state on both instances
        check8("R1 pa_out", pa_o0, 8'h00);
        check8("R1 pc_oe", pc_e0, 8'h00);
        check8("R1 alt pb_oe", pb_e1, 8'h00);
        // R1 R11 control word readback
        bus_read(8'h9F, 1, 0, 1, 8'h9B, "R1 R11 ctrl default map");
        bus_read(8'h5E, 1, 1, 1, 8'h9B, "R1 R11 ctrl alt map");

        pa_in = 8'hA5; pb_in = 8'h3C; pc_in = 8'hF0;
        // R2 default map, all inputs (R8 pins)
        bus_read(8'h9C, 1, 0, 1, 8'hA5, "R2 R8 port A @9C");
        bus_read(8'h9D, 1, 0, 1, 8'h3C, "R2 R8 port B @9D");
        bus_read(8'h9E, 1, 0, 1, 8'hF0, "R2 R8 port C @9E");
        // R3 alternate map
        bus_read(8'h54, 1, 1, 1, 8'hA5, "R3 port A @54");
        bus_read(8'h56, 1, 1, 1, 8'h3C, "R3 port B @56");
        bus_read(8'h5C, 1, 1, 1, 8'hF0, "R3 port C @5C");
        bus_read(8'h9C, 1, 1, 0, 8'h00, "R3 alt ignores 9C");
        bus_read(8'h54, 1, 0, 0, 8'h00, "R2 default ignores 54");
        // R4 deselect
        bus_read(8'h9C, 0, 0, 0, 8'h00, "R4 memory cycle");
        bus_read(8'h98, 1, 0, 0, 8'h00, "R4 address mismatch");

        // R5 all outputs in default map
        bus_write(8'h9F, 1, 8'h80, 0);
        check8("R5 pa_oe", pa_e0, 8'hFF);
        check8("R5 pb_oe", pb_e0, 8'hFF);
        check8("R5 pc_oe", pc_e0, 8'hFF);
        check8("R4 alt untouched oe", pa_e1, 8'h00);

        // R7 latches
        bus_write(8'h9C, 1, 8'h11, 0);
        bus_write(8'h9D, 1, 8'h22, 0);
        bus_write(8'h9E, 1, 8'h33, 0);
        check8("R7 pa_out", pa_o0, 8'h11);
        check8("R7 pb_out", pb_o0, 8'h22);
        check8("R7 pc_out", pc_o0, 8'h33);
        check8("R4 alt pa_out", pa_o1, 8'h00);
        bus_read(8'h9C, 1, 0, 1, 8'h11, "R8 output reads latch");

        // R6 ignored control write
        bus_write(8'h9F, 1, 8'h19, 0);
        check8("R6 pa_oe kept", pa_e0, 8'hFF);
        bus_read(8'h9F, 1, 0, 1, 8'h80, "R6 R11 ctrl kept");

        // R5 R8 split port C: upper input, lower output
        bus_write(8'h9F, 1, 8'h88, 0);
        check8("R5 pc_oe split", pc_e0, 8'h0F);
        bus_read(8'h9E, 1, 0, 1, 8'hF3, "R8 port C nibble mix");
        bus_read(8'h9F, 1, 0, 1, 8'h88, "R11 ctrl readback");

        // R10 collision
        bus_write(8'h9C, 1, 8'hEE, 1);
        check8("R10 pa_out kept", pa_o0, 8'h11);
        // R4 write in memory cycle
        bus_write(8'h9C, 0, 8'h77, 0);
        check8("R4 write ignored", pa_o0, 8'h11);

        // R3 R5 alternate map writes
        bus_write(8'h5E, 1, 8'h90, 0);
        check8("R5 alt pa_oe", pa_e1, 8'h00);
        check8("R5 alt pb_oe", pb_e1, 8'hFF);
        bus_write(8'h56, 1, 8'h5A, 0);
        check8("R3 R7 alt pb_out", pb_o1, 8'h5A);
        check8("R2 default pb_out kept", pb_o0, 8'h22);
        bus_read(8'h56, 1, 1, 1, 8'h5A, "R3 R8 alt port B latch");

        // R1 second reset
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check8("R1 pa_out cleared", pa_o0, 8'h00);
        check8("R1 alt pb_out cleared", pb_o1, 8'h00);
        check8("R1 pc_oe cleared", pc_e0, 8'h00);

        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule